// File: doc/BRIEF.md
# Center-Aligned PWM Channel

This block produces one pulse-width-modulated output whose 8-bit counter climbs from zero to a programmed period and then falls back to zero. Because the counter retraces its path, each duty match happens twice per cycle, once on the way up and once on the way down. The pulse therefore sits symmetrically about the counter's zero point, and the output period is twice the period value, counted in count-enable ticks.

Software writes period and duty through two write strobes into shadow registers. The running channel takes these values into its working registers only when the down-count lands on zero. While the channel is disabled, the working registers follow the shadows on every clock. A polarity input sets the level the output takes during the duty part of the cycle. The counter moves only on a prescaled tick input. Control and loading are done by a four-state machine with these states:

- `ST_OFF`: disabled.
- `ST_HOLD`: enabled with a period of zero.
- `ST_UP`: counting up.
- `ST_DOWN`: counting down.

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| start | `ST_OFF` | `ST_UP` | enabled, shadow period non-zero |
| start-hold | `ST_OFF` | `ST_HOLD` | enabled, shadow period zero |
| turn-down | `ST_UP` | `ST_DOWN` | counter reaches the period |
| turn-up | `ST_DOWN` | `ST_UP` | counter reaches zero with a non-zero new period |
| park | `ST_DOWN` | `ST_HOLD` | counter reaches zero with a zero new period |
| wake | `ST_HOLD` | `ST_UP` | a tick sees a non-zero shadow period |
| stop | any state | `ST_OFF` | enable is low |

Top module: `cap_pwm`

## Requirements
- R1: While reset is asserted, `pwm_out` is 0.
- R2: One clock after `chan_en` is low, `pwm_out` equals the inverse of `polarity` (the idle level). Shadow writes made while disabled do not change this level.
- R3: After the clock edge that sees `chan_en` high with a non-zero period, the counter is 0 and counting up. Each tick adds one, until the tick that would reach the period sets the counter to the period and turns the direction down.
- R4: Counting down, each tick subtracts one. The tick that reaches 0 turns the direction back up. One output cycle is therefore 2×period ticks.
- R5: The output is at its active level when counting up with counter < duty, or counting down with counter ≤ duty. This gives 2×min(duty, period) active ticks per cycle, symmetric about zero.
- R6: If duty ≥ period (period non-zero), the output stays at the active level for the whole cycle.
- R7: If duty = 0, the output stays at the inactive level.
- R8: A period of 0 holds the counter at 0 and the output at the inactive level. On a later tick, a non-zero shadow period starts counting up from 0.
- R9: A write to either shadow while running takes effect only at the tick where the down-count reaches 0. That tick's new counting step already uses the new values.
- R10: Without `tick`, the counter and the output stay unchanged while enabled.
- R11: The active level equals `polarity`, and the inactive level is its inverse.
- R12: Lowering and raising `chan_en` restarts the cycle from counter 0, counting up, with the current shadow values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tick | input | 1 | prescaled count enable |
| chan_en | input | 1 | channel enable |
| per_wr | input | 1 | period shadow write strobe |
| per_wdata | input | 8 | period write data |
| duty_wr | input | 1 | duty shadow write strobe |
| duty_wdata | input | 8 | duty write data |
| polarity | input | 1 | active output level |
| pwm_out | output | 1 | PWM output |

## Verification
The output flip-flop is loaded from the machine's next state, so `pwm_out` reflects a counting step at the same edge where the counter moves. That is one edge after a tick or enable is presented. A register write needs one edge to reach the shadow, and a further reload edge to reach the output. The bench drives every input on the falling edge and samples on the next falling edge. It indexes the expected waveform by the number of edges since enable, so each comparison lands in the cycle where that result is due.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HOLD = 2'd1,
        ST_UP   = 2'd2,
        ST_DOWN = 2'd3
    } cap_state_e;
endpackage

// File: rtl/cap_dbuf.sv
module cap_dbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         per_wr_i,
    input  logic [W-1:0] per_wdata_i,
    input  logic         duty_wr_i,
    input  logic [W-1:0] duty_wdata_i,
    input  logic         load_i,
    output logic [W-1:0] sh_per_o,
    output logic [W-1:0] act_per_o,
    output logic [W-1:0] duty_nxt_o
);
    logic [W-1:0] sh_per_q, sh_duty_q;
    logic [W-1:0] act_per_q, act_duty_q;

    // shadow copies: written on any clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_per_q  <= '0;
            sh_duty_q <= '0;
        end else begin
            if (per_wr_i)  sh_per_q  <= per_wdata_i;
            if (duty_wr_i) sh_duty_q <= duty_wdata_i;
        end
    end

    // working copies: only on the load strobe from the sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_per_q  <= '0;
            act_duty_q <= '0;
        end else if (load_i) begin
            act_per_q  <= sh_per_q;
            act_duty_q <= sh_duty_q;
        end
    end

    assign sh_per_o   = sh_per_q;
    assign act_per_o  = act_per_q;
    assign duty_nxt_o = load_i ? sh_duty_q : act_duty_q;

    // R9: working values never move outside a load
    p_no_stray_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> ($stable(act_per_q) && $stable(act_duty_q)));
endmodule

// File: rtl/cap_seq.sv
module cap_seq
    import cap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         en_i,
    input  logic [W-1:0] sh_per_i,
    input  logic [W-1:0] act_per_i,
    output cap_state_e   state_nxt_o,
    output logic [W-1:0] cnt_nxt_o,
    output logic         load_o
);
    localparam logic [W-1:0] ONE = W'(1);

    cap_state_e   state_q, state_nxt;
    logic [W-1:0] cnt_q, cnt_nxt;
    logic         load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            cnt_q   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state_q;
        cnt_nxt   = cnt_q;
        load      = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                load    = 1'b1;
                cnt_nxt = '0;
                if (en_i) state_nxt = (sh_per_i == '0) ? ST_HOLD : ST_UP;
            end
            ST_HOLD: begin
                cnt_nxt = '0;
                if (!en_i) begin
                    state_nxt = ST_OFF;
                end else if (tick_i) begin
                    load = 1'b1;
                    if (sh_per_i != '0) state_nxt = ST_UP;
                end
            end
            ST_UP: begin
                if (!en_i) begin
                    state_nxt = ST_OFF;
                    cnt_nxt   = '0;
                end else if (tick_i) begin
                    if (cnt_q == act_per_i - ONE) begin
                        cnt_nxt   = act_per_i;
                        state_nxt = ST_DOWN;
                    end else begin
                        cnt_nxt = cnt_q + ONE;
                    end
                end
            end
            ST_DOWN: begin
                if (!en_i) begin
                    state_nxt = ST_OFF;
                    cnt_nxt   = '0;
                end else if (tick_i) begin
                    if (cnt_q == ONE) begin
                        cnt_nxt   = '0;
                        load      = 1'b1;
                        state_nxt = (sh_per_i == '0) ? ST_HOLD : ST_UP;
                    end else begin
                        cnt_nxt = cnt_q - ONE;
                    end
                end
            end
            default: begin
                state_nxt = ST_OFF;
                cnt_nxt   = '0;
            end
        endcase
    end

    assign state_nxt_o = state_nxt;
    assign cnt_nxt_o   = cnt_nxt;
    assign load_o      = load;

    // R4: a running counter never passes the working period
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP || state_q == ST_DOWN) |-> (cnt_q <= act_per_i));
    // R3: the top of the up-count turns the direction
    p_turn_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP && en_i && tick_i && cnt_q == act_per_i - ONE)
        |=> (state_q == ST_DOWN && cnt_q == $past(act_per_i)));
    // R8: zero period parks the counter
    p_hold_at_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q == '0));
    // R10: no tick, no movement
    p_no_tick_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_UP || state_q == ST_DOWN) && en_i && !tick_i)
        |=> ($stable(cnt_q) && $stable(state_q)));
endmodule

// File: rtl/cap_outstage.sv
module cap_outstage
    import cap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         pol_i,
    input  cap_state_e   state_nxt_i,
    input  logic [W-1:0] cnt_nxt_i,
    input  logic [W-1:0] duty_nxt_i,
    output logic         out_o
);
    logic active;
    logic out_q;

    always_comb begin
        unique case (state_nxt_i)
            ST_UP:   active = (cnt_nxt_i <  duty_nxt_i);
            ST_DOWN: active = (cnt_nxt_i <= duty_nxt_i);
            default: active = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= active ? pol_i : ~pol_i;
    end

    assign out_o = out_q;

    // R2: disabled channel shows the idle level one edge later
    p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (out_q == ~$past(pol_i)));
endmodule

// File: rtl/cap_pwm.sv
module cap_pwm
    import cap_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         chan_en,
    input  logic         per_wr,
    input  logic [W-1:0] per_wdata,
    input  logic         duty_wr,
    input  logic [W-1:0] duty_wdata,
    input  logic         polarity,
    output logic         pwm_out
);
    logic [W-1:0] sh_per, act_per, duty_nxt, cnt_nxt;
    logic         load;
    cap_state_e   state_nxt;

    cap_dbuf #(.W(W)) u_dbuf (
        .clk          (clk),
        .rst_n        (rst_n),
        .per_wr_i     (per_wr),
        .per_wdata_i  (per_wdata),
        .duty_wr_i    (duty_wr),
        .duty_wdata_i (duty_wdata),
        .load_i       (load),
        .sh_per_o     (sh_per),
        .act_per_o    (act_per),
        .duty_nxt_o   (duty_nxt)
    );

    cap_seq #(.W(W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .en_i        (chan_en),
        .sh_per_i    (sh_per),
        .act_per_i   (act_per),
        .state_nxt_o (state_nxt),
        .cnt_nxt_o   (cnt_nxt),
        .load_o      (load)
    );

    cap_outstage #(.W(W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (chan_en),
        .pol_i       (polarity),
        .state_nxt_i (state_nxt),
        .cnt_nxt_i   (cnt_nxt),
        .duty_nxt_i  (duty_nxt),
        .out_o       (pwm_out)
    );
endmodule

// File: tb/cap_pwm_tb_top.sv
module cap_pwm_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       chan_en = 1'b0;
    logic       per_wr = 1'b0;
    logic [7:0] per_wdata = '0;
    logic       duty_wr = 1'b0;
    logic [7:0] duty_wdata = '0;
    logic       polarity = 1'b1;
    logic       pwm_out;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    cap_pwm dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .chan_en(chan_en),
        .per_wr(per_wr), .per_wdata(per_wdata), .duty_wr(duty_wr),
        .duty_wdata(duty_wdata), .polarity(polarity), .pwm_out(pwm_out)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: pwm_out=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // expected level k edges after the enabling edge, tick every clock
    function automatic logic exp_lvl(int k, int per, int duty, logic pol);
        int p, c;
        logic up, act;
        if (per == 0) return ~pol;
        p  = k % (2 * per);
        up = (p < per);
        c  = up ? p : 2 * per - p;
        act = up ? (c < duty) : (c <= duty);
        return act ? pol : ~pol;
    endfunction

    // called on a falling edge; writes land on the next rising edge
    task automatic set_regs(input int per, input int duty);
        per_wr = 1'b1; per_wdata = 8'(per);
        duty_wr = 1'b1; duty_wdata = 8'(duty);
        @(negedge clk);
        per_wr = 1'b0; duty_wr = 1'b0;
    endtask

    task automatic go_off();
        chan_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_pattern(input string tag, input int n, input int k0,
                                 input int per, input int duty);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(tag, pwm_out, exp_lvl(k0 + i, per, duty, polarity));
        end
    endtask

    task automatic t_reset();
        #5;
        chk("R1 reset", pwm_out, 1'b0);
        @(negedge clk);
        chk("R1 reset", pwm_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle after reset", pwm_out, ~polarity);
    endtask

    task automatic t_basic();
        int cnt_act = 0;
        polarity = 1'b1; tick = 1'b1;
        @(negedge clk);
        set_regs(4, 1);
        @(negedge clk);
        chan_en = 1'b1;
        check_pattern("R3 R4 R11 basic", 16, 0, 4, 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (pwm_out === polarity) cnt_act++;
        end
        total++;
        if (cnt_act != 2) begin
            bad++;
            $display("FAIL R5 active ticks=%0d expected=2", cnt_act);
        end
    endtask

    task automatic t_disable();
        chan_en = 1'b0;
        @(negedge clk);
        chk("R2 disable idle", pwm_out, ~polarity);
        set_regs(5, 2);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 writes while off", pwm_out, ~polarity);
        end
        chan_en = 1'b1;
        check_pattern("R12 restart R5", 20, 0, 5, 2);
        go_off();
    endtask

    task automatic t_pol0();
        polarity = 1'b0;
        @(negedge clk);
        chk("R11 idle pol0", pwm_out, 1'b1);
        set_regs(3, 2);
        @(negedge clk);
        chan_en = 1'b1;
        check_pattern("R11 R5 pol0", 12, 0, 3, 2);
        go_off();
        polarity = 1'b1;
    endtask

    task automatic t_full_and_empty();
        set_regs(5, 7);
        @(negedge clk);
        chan_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R6 duty>=period", pwm_out, polarity);
        end
        go_off();
        set_regs(5, 0);
        @(negedge clk);
        chan_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R7 duty zero", pwm_out, ~polarity);
        end
        go_off();
    endtask

    task automatic t_shadow();
        set_regs(4, 1);
        @(negedge clk);
        chan_en = 1'b1;
        check_pattern("R9 before write", 3, 0, 4, 1);
        per_wr = 1'b1; per_wdata = 8'd2;
        duty_wr = 1'b1; duty_wdata = 8'd1;
        @(negedge clk);
        per_wr = 1'b0; duty_wr = 1'b0;
        chk("R9 old values kept", pwm_out, exp_lvl(3, 4, 1, polarity));
        check_pattern("R9 old values kept", 4, 4, 4, 1);
        check_pattern("R9 new values at zero", 8, 0, 2, 1);
        go_off();
    endtask

    task automatic t_zero_period();
        set_regs(0, 3);
        @(negedge clk);
        chan_en = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R8 zero period", pwm_out, ~polarity);
        end
        per_wr = 1'b1; per_wdata = 8'd3;
        duty_wr = 1'b1; duty_wdata = 8'd1;
        @(negedge clk);
        per_wr = 1'b0; duty_wr = 1'b0;
        chk("R8 still parked", pwm_out, ~polarity);
        check_pattern("R8 wake", 12, 0, 3, 1);
        go_off();
    endtask

    task automatic t_tick();
        tick = 1'b0;
        set_regs(4, 2);
        @(negedge clk);
        chan_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R10 no tick k0", pwm_out, exp_lvl(0, 4, 2, polarity));
        end
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R10 one tick k1", pwm_out, exp_lvl(1, 4, 2, polarity));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 no tick k1", pwm_out, exp_lvl(1, 4, 2, polarity));
        end
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R10 one tick k2", pwm_out, exp_lvl(2, 4, 2, polarity));
        tick = 1'b1;
        go_off();
    endtask

    initial begin
        #(20 * 150000);
        bad++; total++;
        $display("FAIL watchdog: run=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_disable();
        t_pol0();
        t_full_and_empty();
        t_shadow();
        t_zero_period();
        t_tick();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule